// File: doc/BRIEF.md
# DMA Address Sequencer

This block generates the source and destination addresses for one DMA channel while data items move. While the channel is idle, software writes a 32-bit mode word. The word sets the item size, a separate address direction for each side, an operand length and whether the channel runs in operand or nonstop style. A start pulse then loads both start addresses and a total byte count, and the channel becomes busy.

While busy, the block holds `beat_req_o` high. Each cycle in which `beat_ack_i` is also high counts as one moved item. On each such beat, both addresses move by the item size in their own direction, and the byte count drops by the same step. The block flags the last item of each operand (`op_done_o`) and the item that empties the byte count (`xfer_done_o`). Both flags are combinational, so they are valid in the cycle of the beat. The address registers change at the clock edge that ends that beat.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset the channel is idle: `busy_o`, `beat_req_o`, `op_done_o`, `xfer_done_o` and `cfg_err_o` are 0, both addresses are 0 and `cfg_rdata_o` is 0.
- R2: Mode word fields: size in bits [2:0], source direction in [6:4], destination direction in [10:8], operand code in [15:12], nonstop select in bit 16. `cfg_rdata_o` returns these fields as written, and every other bit reads 0, including the top four.
- R3: A mode write made while `busy_o` is 1 is ignored, and `cfg_rdata_o` keeps its value.
- R4: While the channel is idle, `start_i` with a nonzero `byte_cnt_i` loads both addresses and sets `busy_o` and `beat_req_o`. A start with a zero count is ignored.
- R5: Size codes 0, 1 and 2 give a step of 1, 2 and 4. Direction 1 adds the step on each beat and direction 2 subtracts it. Source and destination each follow their own direction code.
- R6: Direction 0 holds the address at its start value for every size.
- R7: Direction 3 adds the step like direction 1. On the beat that ends an operand, the address returns to the start address loaded by `start_i`.
- R8: In operand style (bit 16 = 0), operand code n gives operands of 2^n items, for n from 0 to 7. `op_done_o` is high on the last beat of each operand and also on the final beat of the transfer.
- R9: In nonstop style (bit 16 = 1), the operand code is ignored. The whole transfer is one operand, so `op_done_o` and the rotate reload happen only on the final beat.
- R10: Each beat lowers the byte count by the step. `xfer_done_o` is high for the single beat that brings the count to zero or below, and `busy_o` is 0 in the next cycle.
- R11: Direction codes 4 to 7 act as direction 0. Size codes 3 to 7 act as size 0. Operand codes 8 to 15 act as code 7. Writing any such code sets `cfg_err_o`, which stays set until reset.
- R12: `beat_ack_i` while idle has no effect on the addresses or the done flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Mode word write strobe |
| cfg_wdata_i | input | 32 | Mode word write data |
| cfg_rdata_o | output | 32 | Mode word readback |
| start_i | input | 1 | Start a transfer |
| src_start_i | input | AW | Source start address |
| dst_start_i | input | AW | Destination start address |
| byte_cnt_i | input | CW | Total byte count |
| beat_req_o | output | 1 | Channel wants a data beat |
| beat_ack_i | input | 1 | Data beat accepted |
| src_addr_o | output | AW | Current source address |
| dst_addr_o | output | AW | Current destination address |
| busy_o | output | 1 | Transfer in progress |
| op_done_o | output | 1 | Current beat ends an operand |
| xfer_done_o | output | 1 | Current beat ends the transfer |
| cfg_err_o | output | 1 | Sticky flag for a reserved code |

## Verification
On every cycle, the assertions check several invariants. A fixed address never moves, and a rotate address lands on its start value at each operand end. The item counter stays inside the operand length. The mode word cannot change while busy. The busy flag drops after the final beat, the error flag is sticky, and idle acknowledges leave the addresses alone. Other behaviour can only be shown by the bench's scenarios: the exact step for each size and direction, which beat numbers carry `op_done_o`, how an odd byte count ends the transfer, the clamping of reserved codes, and the ignored writes and starts.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
  typedef enum logic [1:0] {DIR_FIX = 2'd0, DIR_INC = 2'd1, DIR_DEC = 2'd2, DIR_ROT = 2'd3} dir_e;

  function automatic dir_e dec_dir(input logic [2:0] code);
    return code[2] ? DIR_FIX : dir_e'(code[1:0]);
  endfunction

  function automatic logic [2:0] size_step(input logic [2:0] code);
    case (code)
      3'd1:    return 3'd2;
      3'd2:    return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [2:0] op_clamp(input logic [3:0] code);
    return code[3] ? 3'd7 : code[2:0];
  endfunction
endpackage

// File: rtl/dma_addr_chan.sv
module dma_addr_chan
  import dma_addr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] start_addr_i,
  input  dir_e          dir_i,
  input  logic [2:0]    step_i,
  input  logic          adv_i,
  input  logic          op_end_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q, base_q, step_ext;

  assign step_ext = AW'(step_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      base_q <= '0;
    end else if (load_i) begin
      addr_q <= start_addr_i;
      base_q <= start_addr_i;
    end else if (adv_i) begin
      unique case (dir_i)
        DIR_INC: addr_q <= addr_q + step_ext;
        DIR_DEC: addr_q <= addr_q - step_ext;
        DIR_ROT: addr_q <= op_end_i ? base_q : addr_q + step_ext;
        default: addr_q <= addr_q;
      endcase
    end
  end

  assign addr_o = addr_q;

  p_fixed_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i && dir_i == DIR_FIX |=> $stable(addr_o));
  p_rotate_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i && op_end_i && dir_i == DIR_ROT |=> addr_o == base_q);
endmodule

// File: rtl/dma_xfer_ctl.sv
module dma_xfer_ctl #(
  parameter int CW      = 24,
  parameter int OPC_MAX = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] byte_cnt_i,
  input  logic [2:0]    step_i,
  input  logic [2:0]    op_code_i,
  input  logic          nonstop_i,
  input  logic          ack_i,
  output logic          busy_o,
  output logic          load_o,
  output logic          fire_o,
  output logic          op_end_o,
  output logic          xfer_end_o
);
  localparam int IW = OPC_MAX;

  logic          busy_q;
  logic [CW-1:0] cnt_q, step_ext;
  logic [IW-1:0] item_q;
  logic [IW:0]   op_len_m1;
  logic          op_bound;

  assign step_ext   = CW'(step_i);
  assign load_o     = start_i && !busy_q && byte_cnt_i != '0;
  assign fire_o     = busy_q && ack_i;
  assign op_len_m1  = (IW+1)'((IW+1)'(1) << op_code_i) - (IW+1)'(1);
  assign op_bound   = !nonstop_i && item_q == op_len_m1[IW-1:0];
  assign xfer_end_o = fire_o && cnt_q <= step_ext;
  assign op_end_o   = fire_o && (op_bound || xfer_end_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      item_q <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      cnt_q  <= byte_cnt_i;
      item_q <= '0;
    end else if (fire_o) begin
      item_q <= op_end_o ? '0 : item_q + 1'b1;
      if (xfer_end_o) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q - step_ext;
      end
    end
  end

  assign busy_o = busy_q;

  p_item_in_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !nonstop_i |-> {1'b0, item_q} <= op_len_m1);
  p_done_clears_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_end_o |=> !busy_o);
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_addr_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [31:0]   cfg_wdata_i,
  output logic [31:0]   cfg_rdata_o,
  input  logic          start_i,
  input  logic [AW-1:0] src_start_i,
  input  logic [AW-1:0] dst_start_i,
  input  logic [CW-1:0] byte_cnt_i,
  output logic          beat_req_o,
  input  logic          beat_ack_i,
  output logic [AW-1:0] src_addr_o,
  output logic [AW-1:0] dst_addr_o,
  output logic          busy_o,
  output logic          op_done_o,
  output logic          xfer_done_o,
  output logic          cfg_err_o
);
  localparam int NCH = 2;

  logic [2:0] size_q, sdir_q, ddir_q;
  logic [3:0] opc_q;
  logic       ns_q, err_q;
  logic       busy, load, fire, op_end, xfer_end;
  logic [2:0] step;
  logic       wr_ok, wr_bad;

  assign wr_ok  = cfg_we_i && !busy;
  assign wr_bad = cfg_wdata_i[6] || cfg_wdata_i[10] || cfg_wdata_i[15]
                  || cfg_wdata_i[2:0] > 3'd2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q <= '0;
      sdir_q <= '0;
      ddir_q <= '0;
      opc_q  <= '0;
      ns_q   <= 1'b0;
      err_q  <= 1'b0;
    end else if (wr_ok) begin
      size_q <= cfg_wdata_i[2:0];
      sdir_q <= cfg_wdata_i[6:4];
      ddir_q <= cfg_wdata_i[10:8];
      opc_q  <= cfg_wdata_i[15:12];
      ns_q   <= cfg_wdata_i[16];
      err_q  <= err_q | wr_bad;
    end
  end

  assign cfg_rdata_o = {15'd0, ns_q, opc_q, 1'b0, ddir_q, 1'b0, sdir_q, 1'b0, size_q};
  assign step        = size_step(size_q);

  dma_xfer_ctl #(.CW(CW), .OPC_MAX(7)) i_ctl (
    .clk_i, .rst_ni,
    .start_i, .byte_cnt_i,
    .step_i     (step),
    .op_code_i  (op_clamp(opc_q)),
    .nonstop_i  (ns_q),
    .ack_i      (beat_ack_i),
    .busy_o     (busy),
    .load_o     (load),
    .fire_o     (fire),
    .op_end_o   (op_end),
    .xfer_end_o (xfer_end)
  );

  logic [AW-1:0] ch_start [NCH];
  logic [AW-1:0] ch_addr  [NCH];
  dir_e          ch_dir   [NCH];

  assign ch_start[0] = src_start_i;
  assign ch_start[1] = dst_start_i;
  assign ch_dir[0]   = dec_dir(sdir_q);
  assign ch_dir[1]   = dec_dir(ddir_q);

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dma_addr_chan #(.AW(AW)) i_chan (
      .clk_i, .rst_ni,
      .load_i       (load),
      .start_addr_i (ch_start[c]),
      .dir_i        (ch_dir[c]),
      .step_i       (step),
      .adv_i        (fire),
      .op_end_i     (op_end),
      .addr_o       (ch_addr[c])
    );
  end

  assign src_addr_o  = ch_addr[0];
  assign dst_addr_o  = ch_addr[1];
  assign busy_o      = busy;
  assign beat_req_o  = busy;
  assign op_done_o   = op_end;
  assign xfer_done_o = xfer_end;
  assign cfg_err_o   = err_q;

  p_cfg_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(cfg_rdata_o));
  p_err_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);
  p_idle_ack_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(src_addr_o) && $stable(dst_addr_o));
  p_done_in_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !op_done_o && !xfer_done_o);
endmodule

// File: tb/test_dma_addr_seq.sv
module test_dma_addr_seq;
  localparam int AW = 32;
  localparam int CW = 24;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          start = 1'b0;
  logic [AW-1:0] src_start = '0, dst_start = '0;
  logic [CW-1:0] byte_cnt = '0;
  logic          beat_req, beat_ack = 1'b0;
  logic [AW-1:0] src_addr, dst_addr;
  logic          busy, op_done, xfer_done, cfg_err;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  dma_addr_seq #(.AW(AW), .CW(CW)) i_dma_addr_seq (
    .clk_i(clk), .rst_ni, .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .start_i(start), .src_start_i(src_start),
    .dst_start_i(dst_start), .byte_cnt_i(byte_cnt), .beat_req_o(beat_req),
    .beat_ack_i(beat_ack), .src_addr_o(src_addr), .dst_addr_o(dst_addr),
    .busy_o(busy), .op_done_o(op_done), .xfer_done_o(xfer_done), .cfg_err_o(cfg_err)
  );

  typedef struct packed {
    logic [31:0] cfg;
    logic [31:0] src;
    logic [31:0] dst;
    logic [31:0] cnt;
    logic [31:0] exp_src;
    logic [31:0] exp_dst;
    logic [7:0]  exp_mask;
    logic [7:0]  exp_beats;
  } vec_t;

  // cfg: size[2:0] sdir[6:4] ddir[10:8] opc[15:12] nonstop[16]
  localparam vec_t VEC [6] = '{
    '{32'h0000_0212, 32'h100, 32'h200, 32'd12, 32'h10C, 32'h1F4, 8'h07, 8'd3}, // R5 R8
    '{32'h0000_2130, 32'h040, 32'h080, 32'd6,  32'h040, 32'h086, 8'h28, 8'd6}, // R7 R8
    '{32'h0001_1301, 32'h010, 32'h020, 32'd8,  32'h010, 32'h020, 8'h08, 8'd4}, // R9 R6
    '{32'h0000_7021, 32'h1000,32'h030, 32'd6,  32'hFFA, 32'h030, 8'h04, 8'd3}, // R5 R6
    '{32'h0000_1110, 32'h000, 32'h010, 32'd5,  32'h005, 32'h015, 8'h1A, 8'd5}, // R8
    '{32'h0000_0012, 32'h000, 32'h050, 32'd6,  32'h008, 32'h050, 8'h03, 8'd2}  // R10
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [31:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic do_start(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
    @(negedge clk); start = 1'b1; src_start = s; dst_start = d; byte_cnt = c[CW-1:0];
    @(negedge clk); start = 1'b0;
  endtask

  // drive beats until transfer ends; returns op_done mask and beat count
  task automatic run_beats(output logic [7:0] mask, output int beats);
    mask = '0; beats = 0;
    for (int b = 0; b < 16; b++) begin
      bit fin;
      beat_ack = 1'b1;
      #1;
      if (op_done && b < 8) mask[b] = 1'b1;
      fin = xfer_done;
      beats = b + 1;
      @(negedge clk);
      if (fin) break;
    end
    beat_ack = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input string req);
    logic [7:0] m;
    int nb;
    cfg_write(v.cfg);
    do_start(v.src, v.dst, v.cnt);
    chk(busy && beat_req, {req, " R4 busy after start"}, {30'd0, busy, beat_req}, 32'd3);
    run_beats(m, nb);
    chk(nb == int'(v.exp_beats), {req, " R10 beat count"}, nb, v.exp_beats);
    chk(m == v.exp_mask, {req, " R8 op_done beats"}, m, v.exp_mask);
    chk(src_addr == v.exp_src, {req, " R5 src addr"}, src_addr, v.exp_src);
    chk(dst_addr == v.exp_dst, {req, " R5 dst addr"}, dst_addr, v.exp_dst);
    chk(!busy, {req, " R10 idle after done"}, busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] m;
    int nb;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !beat_req && !op_done && !xfer_done && !cfg_err, "R1 flags", {busy, beat_req, op_done, xfer_done, cfg_err}, 0);
    chk(src_addr == 0 && dst_addr == 0, "R1 addresses", src_addr | dst_addr, 0);
    chk(cfg_rdata == 0, "R1 readback", cfg_rdata, 0);

    // R2 readback masks undefined bits
    cfg_write(32'hF001_1312);
    chk(cfg_rdata == 32'h0001_1312, "R2 readback", cfg_rdata, 32'h0001_1312);

    for (int i = 0; i < 6; i++) run_vec(VEC[i], $sformatf("vec%0d", i));
    chk(!cfg_err, "R11 no error for legal codes", cfg_err, 0);

    // R3 write while busy ignored
    cfg_write(32'h0000_0012);
    do_start(32'h0, 32'h0, 32'd8);
    @(negedge clk); beat_ack = 1'b1;
    @(negedge clk); beat_ack = 1'b0; cfg_we = 1'b1; cfg_wdata = 32'h0000_0111;
    @(negedge clk); cfg_we = 1'b0;
    chk(cfg_rdata == 32'h12, "R3 write ignored while busy", cfg_rdata, 32'h12);
    run_beats(m, nb);
    chk(nb == 1 && src_addr == 32'h8, "R3 transfer kept old mode", src_addr, 32'h8);

    // R12 ack while idle
    @(negedge clk); beat_ack = 1'b1; #1;
    chk(!op_done && !xfer_done, "R12 no done when idle", {op_done, xfer_done}, 0);
    @(negedge clk); @(negedge clk); beat_ack = 1'b0;
    chk(src_addr == 32'h8 && dst_addr == 32'h0, "R12 addr unchanged", src_addr, 32'h8);

    // R4 zero count start ignored
    do_start(32'h999, 32'h777, 32'd0);
    chk(!busy, "R4 zero count no start", busy, 0);
    chk(src_addr == 32'h8, "R4 zero count no load", src_addr, 32'h8);

    // R11 reserved codes: sdir 5 -> fixed, size 3 -> 8-bit, opc 9 -> 7
    cfg_write(32'h0000_9153);
    chk(cfg_err, "R11 error flag set", cfg_err, 1);
    chk(cfg_rdata == 32'h0000_9153, "R2 R11 raw readback", cfg_rdata, 32'h9153);
    do_start(32'h70, 32'h90, 32'd3);
    run_beats(m, nb);
    chk(nb == 3 && m == 8'h04, "R11 clamped size and operand", {m, 8'(nb)}, {8'h04, 8'd3});
    chk(src_addr == 32'h70 && dst_addr == 32'h93, "R11 reserved dir fixed", src_addr, 32'h70);
    cfg_write(32'h0000_0000);
    chk(cfg_err, "R11 error sticky", cfg_err, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule